// File: doc/BRIEF.md
# Two-Wire Bus Target with Broadcast Commands and Stuck-Bus Recovery

This block is the target side of an open-drain two-wire serial bus. It watches the bus clock and data lines, which arrive already synchronised to the system clock. It finds start and stop conditions and shifts in bytes MSB first. It acknowledges by pulling the data line low, and it sends register bytes back when the controller reads. Its 7-bit device address is `100100p`, where `p` is the level of an address-select pin. The block samples that pin at defined moments and holds the value in between.

Towards the register bank the block produces byte beats. The first byte after a write address sets an internal pointer. Each later byte comes out as a write beat that carries the pointer and a high/low half flag. For a read, the block raises a read request for each byte it is about to send and takes that byte from the bank in the same cycle. The block also answers a broadcast address that can re-sample the pin or reset the register bank. It answers an alert-query address, returning its own address plus a status bit and arbitrating bit by bit against other responders. If either line stays low too long during a transfer, it drops the transfer.

The bus cannot be stalled, so neither beat interface has back-pressure. `wr_valid` is a one-cycle beat that the bank must accept in that cycle. `rd_valid` is a one-cycle request, and the bank must drive `rd_data` for the given pointer and half while `rd_valid` is high.

Top module: `twowire_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, `sda_pull_low` is 0 and the block ignores the bus until the next start.
- R2: The block acknowledges an address byte equal to `{6'b100100, p, rw}` by holding SDA low through the high phase of the ninth clock. `p` is sampled after reset, at a start that comes from bus idle, and on a broadcast re-sample command. A repeated start keeps the held value.
- R3: The block does not acknowledge any other address byte. It then acknowledges nothing and produces no beats until the next start.
- R4: In a write, the first byte after the address loads the pointer from its low `PTR_W` bits. Each later byte is acknowledged and produces one `wr_valid` beat carrying that pointer. `wr_half` is 0 for the first such byte and then alternates.
- R5: In a read, the block raises `rd_valid` before each byte and sends `rd_data` MSB first. The first byte has `rd_half`=0, and the half alternates after each byte. A controller not-acknowledge ends the read, and the block drives nothing more.
- R6: The broadcast address byte 0x00 is acknowledged. A following byte 0x04 re-samples `p` only. A following byte 0x06 re-samples `p`, pulses `regs_reset` for one cycle and clears the pointer to 0.
- R7: The alert-query address byte 0x19 (0001100 with the read bit) is acknowledged only while `alert_active` is 1. The block then returns `{6'b100100, p, alert_above}`.
- R8: While returning that byte, if the block leaves SDA released for a 1 and sees SDA low at a clock rise, it stops driving for the rest of the command and does not pulse `alert_clear`.
- R9: If the block returns all eight bits without losing, it pulses `alert_clear` for one cycle at the end of the ninth clock.
- R10: Between a start and a stop, if SCL or SDA stays low for `TIMEOUT_CYCLES` consecutive cycles, the block releases SDA and ignores the bus until a new start.
- R11: After reset, `sda_pull_low`, `wr_valid`, `rd_valid`, `regs_reset` and `alert_clear` are 0, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line |
| sda_pull_low | output | 1 | 1 pulls the data line low |
| addr_pin | input | 1 | Address-select pin level |
| alert_active | input | 1 | Alert currently asserted by the bank |
| alert_above | input | 1 | Alert cause: 1 high limit, 0 low limit |
| alert_clear | output | 1 | One-cycle pulse after an alert query is won |
| wr_valid | output | 1 | Write beat |
| wr_ptr | output | PTR_W | Register index of the write beat |
| wr_half | output | 1 | 0 high byte, 1 low byte |
| wr_data | output | 8 | Written byte |
| rd_valid | output | 1 | Read request for the byte about to be sent |
| rd_ptr | output | PTR_W | Register index of the read request |
| rd_half | output | 1 | 0 high byte, 1 low byte |
| rd_data | input | 8 | Byte from the bank, valid while rd_valid is high |
| regs_reset | output | 1 | One-cycle pulse: restore bank power-up values |

## Verification
The bench targets the pin-sampling moments. A design that re-sampled the pin on a repeated start would acknowledge an address it should refuse. A design that ignored the broadcast re-sample would refuse one it should accept. The bench loses an alert-query arbitration on the first bit. A design that kept driving would corrupt the competitor's bits and would still clear its alert. The bench also holds each line low in turn during a transfer. A design that timed only SCL, or that counted total low time, would either keep holding SDA or abort a normal byte of zeros. A repeated start before a read must keep the pointer, and a not-acknowledge must silence the block.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_SKIP
  } tw_state_e;

  typedef enum logic [1:0] {
    K_ADDR, K_PTR, K_DATA, K_BCAST
  } rx_kind_e;

  localparam logic [6:0] ALERT_QUERY7 = 7'b0001100;
  localparam logic [7:0] BCAST_ADDR8  = 8'h00;
  localparam logic [7:0] BCAST_PIN    = 8'h04;
  localparam logic [7:0] BCAST_RESET  = 8'h06;
  localparam int         BITS_PER_BYTE = 8;
endpackage

// File: rtl/tw_line_events.sv
module tw_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise = scl_i & ~scl_q;
    scl_fall = ~scl_i & scl_q;
    start_c  = scl_i & scl_q & sda_q & ~sda_i;
    stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/tw_stuck_timer.sv
module tw_stuck_timer #(
  parameter int LIMIT = 5_400_000,
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic [LINES-1:0] line_i,
  output logic             expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [LINES-1:0] hit;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (!armed || line_i[g])  cnt <= '0;
      else if (cnt != LIM_M1)        cnt <= cnt + 1'b1;
    end
    assign hit[g] = armed && !line_i[g] && (cnt == LIM_M1);
  end

  assign expired = |hit;
endmodule

// File: rtl/tw_frame_ctrl.sv
module tw_frame_ctrl
  import tw_pkg::*;
#(
  parameter int          PTR_W    = 2,
  parameter logic [5:0]  DEV_BASE = 6'b100100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_c,
  input  logic             stop_c,
  input  logic             expire,
  input  logic             sda_i,
  input  logic             addr_pin,
  input  logic             alert_active,
  input  logic             alert_above,
  input  logic [7:0]       rd_data,
  output logic             sda_pull_low,
  output logic             busy,
  output logic             wr_valid,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             wr_half,
  output logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             rd_half,
  output logic             regs_reset,
  output logic             alert_clear
);
  localparam logic [3:0] FULL = 4'(BITS_PER_BYTE);

  tw_state_e       st;
  rx_kind_e        kind;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic [PTR_W-1:0] ptr;
  logic            half, pin_q, boot, tx_alert, go_tx, mack, oe;

  logic [6:0] own7;
  logic       addr_hit, bcast_hit, query_hit, rx_take, evt_ok;
  logic [7:0] tx_byte;

  always_comb begin
    own7      = {DEV_BASE, pin_q};
    addr_hit  = (shreg[7:1] == own7);
    bcast_hit = (shreg == BCAST_ADDR8);
    query_hit = (shreg == {ALERT_QUERY7, 1'b1}) && alert_active;
    rx_take   = (kind != K_ADDR) || addr_hit || bcast_hit || query_hit;
    tx_byte   = tx_alert ? {own7, alert_above} : rd_data;
    evt_ok    = !expire && !stop_c && !start_c;
    rd_valid  = evt_ok && scl_fall && !tx_alert &&
                (((st == S_RX_ACK) && go_tx) || ((st == S_TX_ACK) && mack));
  end

  assign rd_ptr       = ptr;
  assign rd_half      = half;
  assign sda_pull_low = oe;
  assign busy         = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      kind        <= K_ADDR;
      bitcnt      <= '0;
      shreg       <= '0;
      ptr         <= '0;
      half        <= 1'b0;
      pin_q       <= 1'b0;
      boot        <= 1'b1;
      tx_alert    <= 1'b0;
      go_tx       <= 1'b0;
      mack        <= 1'b0;
      oe          <= 1'b0;
      wr_valid    <= 1'b0;
      wr_ptr      <= '0;
      wr_half     <= 1'b0;
      wr_data     <= '0;
      regs_reset  <= 1'b0;
      alert_clear <= 1'b0;
    end else begin
      wr_valid    <= 1'b0;
      regs_reset  <= 1'b0;
      alert_clear <= 1'b0;
      boot        <= 1'b0;
      if (boot) pin_q <= addr_pin;

      if (expire || stop_c) begin
        st <= S_IDLE;
        oe <= 1'b0;
      end else if (start_c) begin
        if (st == S_IDLE) pin_q <= addr_pin;
        st     <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        oe     <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != FULL) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == FULL) begin
              go_tx <= 1'b0;
              if (rx_take) begin
                oe <= 1'b1;
                st <= S_RX_ACK;
              end else begin
                st <= S_SKIP;
              end
              case (kind)
                K_ADDR: begin
                  if (addr_hit) begin
                    if (shreg[0]) begin
                      go_tx    <= 1'b1;
                      tx_alert <= 1'b0;
                      half     <= 1'b0;
                    end else begin
                      kind <= K_PTR;
                    end
                  end else if (bcast_hit) begin
                    kind <= K_BCAST;
                  end else if (query_hit) begin
                    go_tx    <= 1'b1;
                    tx_alert <= 1'b1;
                  end
                end
                K_PTR: begin
                  ptr  <= shreg[PTR_W-1:0];
                  half <= 1'b0;
                  kind <= K_DATA;
                end
                K_DATA: begin
                  wr_valid <= 1'b1;
                  wr_data  <= shreg;
                  wr_ptr   <= ptr;
                  wr_half  <= half;
                  half     <= ~half;
                end
                default: begin
                  if (shreg == BCAST_PIN || shreg == BCAST_RESET) pin_q <= addr_pin;
                  if (shreg == BCAST_RESET) begin
                    regs_reset <= 1'b1;
                    ptr        <= '0;
                  end
                end
              endcase
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              if (go_tx) begin
                shreg  <= tx_byte;
                oe     <= ~tx_byte[7];
                bitcnt <= 4'd1;
                st     <= S_TX;
              end else begin
                oe     <= 1'b0;
                bitcnt <= '0;
                st     <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise && tx_alert && !oe && !sda_i) begin
              st <= S_SKIP;
            end else if (scl_fall) begin
              if (bitcnt == FULL) begin
                oe <= 1'b0;
                st <= S_TX_ACK;
                if (!tx_alert) half <= ~half;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                oe     <= ~shreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_i;
            end else if (scl_fall) begin
              if (tx_alert) begin
                alert_clear <= 1'b1;
                st          <= S_SKIP;
              end else if (mack) begin
                shreg  <= tx_byte;
                oe     <= ~tx_byte[7];
                bitcnt <= 4'd1;
                st     <= S_TX;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twowire_slave.sv
module twowire_slave #(
  parameter int         TIMEOUT_CYCLES = 5_400_000,
  parameter int         PTR_W          = 2,
  parameter logic [5:0] DEV_BASE       = 6'b100100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_low,
  input  logic             addr_pin,
  input  logic             alert_active,
  input  logic             alert_above,
  output logic             alert_clear,
  output logic             wr_valid,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             wr_half,
  output logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             rd_half,
  input  logic [7:0]       rd_data,
  output logic             regs_reset
);
  logic ev_rise, ev_fall, ev_start, ev_stop, tmo_hit, xfer_open;

  tw_line_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(ev_rise), .scl_fall(ev_fall), .start_c(ev_start), .stop_c(ev_stop)
  );

  tw_stuck_timer #(.LIMIT(TIMEOUT_CYCLES), .LINES(2)) u_tmo (
    .clk(clk), .rst_n(rst_n), .armed(xfer_open),
    .line_i({scl_i, sda_i}), .expired(tmo_hit)
  );

  tw_frame_ctrl #(.PTR_W(PTR_W), .DEV_BASE(DEV_BASE)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(ev_rise), .scl_fall(ev_fall), .start_c(ev_start), .stop_c(ev_stop),
    .expire(tmo_hit), .sda_i(sda_i), .addr_pin(addr_pin),
    .alert_active(alert_active), .alert_above(alert_above), .rd_data(rd_data),
    .sda_pull_low(sda_pull_low), .busy(xfer_open),
    .wr_valid(wr_valid), .wr_ptr(wr_ptr), .wr_half(wr_half), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ptr(rd_ptr), .rd_half(rd_half),
    .regs_reset(regs_reset), .alert_clear(alert_clear)
  );
endmodule

// File: rtl/tw_slave_checker.sv
module tw_slave_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_low,
  input logic stop_seen,
  input logic expired,
  input logic wr_valid,
  input logic rd_valid,
  input logic regs_reset,
  input logic alert_clear
);
  p_release_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_pull_low);

  p_pull_only_clock_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !$past(scl_i));

  p_one_beat_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));

  p_write_beat_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  p_bank_reset_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    regs_reset |=> !regs_reset);

  p_alert_clear_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clear |=> !alert_clear);

  p_release_on_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !sda_pull_low);
endmodule

bind twowire_slave tw_slave_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_low(sda_pull_low),
  .stop_seen(ev_stop), .expired(tmo_hit), .wr_valid(wr_valid), .rd_valid(rd_valid),
  .regs_reset(regs_reset), .alert_clear(alert_clear)
);

// File: tb/sim_twowire_slave.sv
`timescale 1ns/1ps
module sim_twowire_slave;
  localparam int TO = 1500;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_pin = 1'b0, alert_active = 1'b0, alert_above = 1'b0;
  logic sda_pull_low, alert_clear, wr_valid, wr_half, rd_valid, rd_half, regs_reset;
  logic [1:0] wr_ptr, rd_ptr;
  logic [7:0] wr_data, rd_data;
  logic sda_line;

  int nchk = 0, nfail = 0;
  int wr_cnt = 0, rd_cnt = 0, rst_cnt = 0, clr_cnt = 0;
  logic [7:0] wr_log_d [64];
  logic       wr_log_h [64];
  logic [1:0] wr_log_p [64];
  logic [1:0] rd_log_p [64];
  logic       rd_log_h [64];
  bit done = 0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_low;
  assign rd_data  = rd_half ? (8'h3C ^ {6'd0, rd_ptr}) : (8'hA5 ^ {6'd0, rd_ptr});

  twowire_slave #(.TIMEOUT_CYCLES(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_low(sda_pull_low), .addr_pin(addr_pin),
    .alert_active(alert_active), .alert_above(alert_above), .alert_clear(alert_clear),
    .wr_valid(wr_valid), .wr_ptr(wr_ptr), .wr_half(wr_half), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ptr(rd_ptr), .rd_half(rd_half), .rd_data(rd_data),
    .regs_reset(regs_reset)
  );

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (wr_valid) begin
        wr_log_d[wr_cnt % 64] = wr_data;
        wr_log_h[wr_cnt % 64] = wr_half;
        wr_log_p[wr_cnt % 64] = wr_ptr;
        wr_cnt++;
      end
      if (rd_valid) begin
        rd_log_p[rd_cnt % 64] = rd_ptr;
        rd_log_h[rd_cnt % 64] = rd_half;
        rd_cnt++;
      end
      if (regs_reset)  rst_cnt++;
      if (alert_clear) clr_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic m_bit(input logic b, output logic seen);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    seen = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic m_rbyte(input logic [7:0] drive, input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(drive[i], s);
      b[i] = s;
    end
    m_bit(~give_ack, s);
  endtask

  // {pin, address byte, pointer byte, data byte, expected acknowledge}
  localparam logic [25:0] VEC [0:5] = '{
    {1'b0, 8'h90, 8'h01, 8'h5E, 1'b1},
    {1'b1, 8'h92, 8'h02, 8'hC7, 1'b1},
    {1'b0, 8'h92, 8'h03, 8'h11, 1'b0},
    {1'b1, 8'h90, 8'h01, 8'h22, 1'b0},
    {1'b0, 8'h18, 8'h00, 8'h33, 1'b0},
    {1'b1, 8'hB2, 8'h03, 8'h44, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] b0, b1, b2;
    int w0, r0, c0, k0;

    repeat (5) @(negedge clk);
    // R11: reset state
    chk("R11 sda released in reset", sda_pull_low, 0);
    chk("R11 no write beat in reset", wr_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 no read/reset/clear after reset", {rd_valid, regs_reset, alert_clear}, 0);

    // Table walk: R2 match, R3 mismatch ignored, R4 single write beat
    alert_active = 1'b1;
    for (int v = 0; v < 6; v++) begin
      addr_pin = VEC[v][25];
      wait_q();
      w0 = wr_cnt;
      m_start();
      m_wbyte(VEC[v][24:17], a0);
      m_wbyte(VEC[v][16:9], a1);
      m_wbyte(VEC[v][8:1], a2);
      m_stop();
      chk("R2/R3 address acknowledge", a0, VEC[v][0]);
      chk("R3/R4 later bytes acknowledge", {a1, a2}, {2{VEC[v][0]}});
      chk("R3/R4 write beat count", wr_cnt - w0, VEC[v][0] ? 1 : 0);
      if (VEC[v][0]) begin
        chk("R4 beat ptr/half/data", {wr_log_p[w0 % 64], wr_log_h[w0 % 64], wr_log_d[w0 % 64]},
            {VEC[v][10:9], 1'b0, VEC[v][8:1]});
      end
      chk("R1 released after stop", sda_pull_low, 0);
    end
    alert_active = 1'b0;
    addr_pin = 1'b0;
    wait_q();

    // R4: two data bytes alternate halves
    w0 = wr_cnt;
    m_start(); m_wbyte(8'h90, a0); m_wbyte(8'h02, a1); m_wbyte(8'hAB, a2); m_wbyte(8'hCD, a3); m_stop();
    chk("R4 two beats", wr_cnt - w0, 2);
    chk("R4 first beat", {wr_log_h[w0 % 64], wr_log_d[w0 % 64]}, {1'b0, 8'hAB});
    chk("R4 second beat", {wr_log_h[(w0 + 1) % 64], wr_log_p[(w0 + 1) % 64], wr_log_d[(w0 + 1) % 64]},
        {1'b1, 2'd2, 8'hCD});

    // R5: pointer write, repeated start, read two bytes, then NACK ends it
    r0 = rd_cnt;
    m_start(); m_wbyte(8'h90, a0); m_wbyte(8'h02, a1);
    m_start(); m_wbyte(8'h91, a2);
    m_rbyte(8'hFF, 1'b1, b0);
    m_rbyte(8'hFF, 1'b0, b1);
    m_rbyte(8'hFF, 1'b0, b2);
    m_stop();
    chk("R5 read address ack", a2, 1);
    chk("R5 high byte first", b0, 8'hA7);
    chk("R5 low byte second", b1, 8'h3E);
    chk("R5 silent after nack", b2, 8'hFF);
    chk("R5 two read requests", rd_cnt - r0, 2);
    chk("R5 request halves and ptr", {rd_log_h[r0 % 64], rd_log_h[(r0 + 1) % 64], rd_log_p[r0 % 64]},
        {1'b0, 1'b1, 2'd2});

    // R2: repeated start keeps the held pin value
    addr_pin = 1'b0; wait_q();
    m_start(); m_wbyte(8'h90, a0);
    addr_pin = 1'b1;
    m_start(); m_wbyte(8'h92, a1); m_stop();
    chk("R2 repeated start does not resample", {a0, a1}, {1'b1, 1'b0});

    // R6: broadcast 0x04 resamples pin without bank reset
    addr_pin = 1'b0; wait_q();
    k0 = rst_cnt;
    m_start(); m_wbyte(8'h00, a0);
    addr_pin = 1'b1;
    m_wbyte(8'h04, a1);
    m_start(); m_wbyte(8'h92, a2); m_stop();
    chk("R6 broadcast 0x04 resample", {a0, a1, a2}, 3'b111);
    chk("R6 no reset on 0x04", rst_cnt - k0, 0);

    // R6: broadcast 0x06 resets bank and pointer
    addr_pin = 1'b0; wait_q();
    m_start(); m_wbyte(8'h90, a0); m_wbyte(8'h03, a1); m_stop();
    k0 = rst_cnt;
    m_start(); m_wbyte(8'h00, a0); m_wbyte(8'h06, a1); m_stop();
    chk("R6 reset pulse once", rst_cnt - k0, 1);
    r0 = rd_cnt;
    m_start(); m_wbyte(8'h91, a0); m_rbyte(8'hFF, 1'b0, b0); m_stop();
    chk("R6 pointer cleared", {rd_log_p[r0 % 64], b0}, {2'd0, 8'hA5});

    // R7: alert query ignored while alert inactive
    c0 = clr_cnt;
    m_start(); m_wbyte(8'h19, a0); m_stop();
    chk("R7 no ack without alert", a0, 0);

    // R7/R9: query won, returns address and status
    alert_active = 1'b1; alert_above = 1'b1; addr_pin = 1'b1; wait_q();
    m_start(); m_wbyte(8'h19, a0); m_rbyte(8'hFF, 1'b0, b0); m_stop();
    chk("R7 query ack", a0, 1);
    chk("R7 returned address+status", b0, 8'h93);
    chk("R9 alert cleared once", clr_cnt - c0, 1);

    alert_above = 1'b0; addr_pin = 1'b0; wait_q();
    c0 = clr_cnt;
    m_start(); m_wbyte(8'h19, a0); m_rbyte(8'hFF, 1'b0, b0); m_stop();
    chk("R7 low-limit status", b0, 8'h90);

    // R8: lose arbitration on first bit
    c0 = clr_cnt;
    m_start(); m_wbyte(8'h19, a0); m_rbyte(8'h7F, 1'b0, b0); m_stop();
    chk("R8 line shows competitor only", b0, 8'h7F);
    chk("R8 no alert clear after loss", clr_cnt - c0, 0);
    alert_active = 1'b0;

    // R10: SCL held low while slave acknowledges
    begin
      logic s;
      m_start();
      for (int i = 7; i >= 0; i--) m_bit(8'h90 >> i, s);
      sda_m = 1'b1; wait_q();
      chk("R10 acking before stall", sda_pull_low, 1);
      repeat (TO + 50) @(negedge clk);
      chk("R10 released after SCL stall", sda_pull_low, 0);
      scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
      m_wbyte(8'h01, a0);
      m_stop();
      chk("R10 ignored after timeout", a0, 0);
    end
    m_start(); m_wbyte(8'h90, a0); m_stop();
    chk("R10 recovers on new start", a0, 1);

    // R10: SDA held low with SCL high after start
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0;
    repeat (TO + 50) @(negedge clk);
    scl_m = 1'b0; wait_q();
    m_wbyte(8'h90, a0);
    m_stop();
    chk("R10 SDA stall drops transfer", a0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule